// File: doc/BRIEF.md
# Integer ALU with Two-Level Operation Decode

This block is the arithmetic unit of a simple load/store processor together with its local operation decoder. The main controller supplies a 2-bit operation class. When that class calls for an R-type decode, the low four bits of the instruction's 6-bit function field choose the operation. The decoder turns the class and the function bits into a 4-bit internal operation code. That code selects AND, OR, add, subtract or signed set-on-less-than, applied to two 32-bit operands.

The block computes the result and a zero flag, which a branch-on-equal uses to decide whether the branch is taken. Both the decode and the operation logic are combinational. The result and the flag are captured in an output register, so each set of inputs applied before a rising clock edge appears on the outputs just after that edge. A synchronous, active-high reset clears the output register.

Top module: `alu_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0 and `zero` becomes 1. The values on the other inputs have no effect on this.
- R2: When `op_class` is 2'b00, the block adds the operands (`opnd_a + opnd_b`), whatever the value of `func`.
- R3: When bit 0 of `op_class` is 1 (2'b01 or 2'b11), the block subtracts (`opnd_a - opnd_b`), whatever the value of `func`.
- R4: When `op_class` is 2'b10, `func` selects the operation: 6'b100000 is add, 6'b100010 is subtract, 6'b100100 is bitwise AND, 6'b100101 is bitwise OR and 6'b101010 is set-on-less-than.
- R5: When `op_class` is 2'b10, bits 5 and 4 of `func` are ignored. A code that matches a listed entry in bits 3..0 gives that entry's operation.
- R6: When `op_class` is 2'b10 and `func[3:0]` matches none of 4'b0000, 4'b0010, 4'b0100, 4'b0101 or 4'b1010, the block adds.
- R7: Set-on-less-than treats both operands as signed two's-complement numbers. It returns 32'd1 when `opnd_a < opnd_b` and 32'd0 otherwise.
- R8: Add and subtract wrap modulo 2^32. No overflow indication exists.
- R9: `zero` is 1 exactly when `result` is 0. The two change together on the same edge.
- R10: Inputs sampled at a rising edge determine `result` and `zero` right after that edge. Between edges the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_class | input | 2 | Operation class from the main controller |
| func | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Registered operation result |
| zero | output | 1 | Registered flag, high when `result` is zero |

## Verification
Wraparound and zero detection can occur in the same cycle. This happens when an add of 32'hFFFFFFFF and 1 wraps to zero, or when a forced subtract of equal operands yields zero. The bench applies both cases and requires `zero` to rise together with the wrapped result. Set-on-less-than and zero detection also coincide when a false comparison yields 0. The bench provokes this with equal operands and with operands of mixed sign, and checks that `zero` goes high on the same edge as the 0 result.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Internal operation codes (values fixed by the decode contract)
  typedef enum logic [3:0] {
    OPC_AND = 4'b0000,
    OPC_OR  = 4'b0001,
    OPC_ADD = 4'b0010,
    OPC_SUB = 4'b0110,
    OPC_SLT = 4'b0111
  } opc_e;

  // Operation classes from the main controller
  localparam logic [1:0] CLS_MEM   = 2'b00;
  localparam logic [1:0] CLS_RTYPE = 2'b10;

  // Low function-field nibbles recognised in the R-type class
  localparam logic [3:0] FN_ADD = 4'b0000;
  localparam logic [3:0] FN_SUB = 4'b0010;
  localparam logic [3:0] FN_AND = 4'b0100;
  localparam logic [3:0] FN_OR  = 4'b0101;
  localparam logic [3:0] FN_SLT = 4'b1010;

endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
  import alu_pkg::*;
#(
  parameter int CLASS_W = 2,
  parameter int DEC_W   = 4
) (
  input  logic [CLASS_W-1:0] op_class,
  input  logic [DEC_W-1:0]   fn_low,
  output opc_e               opc
);

  opc_e rtype_opc;

  // Second level: function nibble to operation
  always_comb begin
    unique case (fn_low)
      FN_ADD:  rtype_opc = OPC_ADD;
      FN_SUB:  rtype_opc = OPC_SUB;
      FN_AND:  rtype_opc = OPC_AND;
      FN_OR:   rtype_opc = OPC_OR;
      FN_SLT:  rtype_opc = OPC_SLT;
      default: rtype_opc = OPC_ADD;   // unlisted codes fall back to add
    endcase
  end

  // First level: class bit 0 dominates, then bit 1 enables the R-type decode
  always_comb begin
    if (op_class[0])
      opc = OPC_SUB;
    else if (op_class[1])
      opc = rtype_opc;
    else
      opc = OPC_ADD;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit SLT_SIGNED = 1'b1
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  opc_e              opc,
  output logic [DATA_W-1:0] y
);

  localparam int MSB = DATA_W - 1;

  logic              do_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_ext;
  logic              less;

  // One shared adder serves add, subtract and the compare
  assign do_sub  = (opc == OPC_SUB) || (opc == OPC_SLT);
  assign b_eff   = do_sub ? ~b : b;
  assign sum_ext = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};

  generate
    if (SLT_SIGNED) begin : g_slt_signed
      // Differing signs: the negative operand is smaller; else the
      // difference sign decides (no overflow possible then)
      assign less = (a[MSB] != b[MSB]) ? a[MSB] : sum_ext[MSB];
    end else begin : g_slt_unsigned
      assign less = ~sum_ext[DATA_W];
    end
  endgenerate

  always_comb begin
    unique case (opc)
      OPC_AND: y = a & b;
      OPC_OR:  y = a | b;
      OPC_SLT: y = {{(DATA_W-1){1'b0}}, less};
      default: y = sum_ext[MSB:0];
    endcase
  end

endmodule

// File: rtl/zero_detect.sv
module zero_detect #(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 8
) (
  input  logic [DATA_W-1:0] val,
  output logic              is_zero
);

  localparam int N_GRP = (DATA_W + GROUP_W - 1) / GROUP_W;
  localparam int PAD_W = N_GRP * GROUP_W;

  logic [PAD_W-1:0] padded;
  logic [N_GRP-1:0] grp_any;

  assign padded = {{(PAD_W-DATA_W){1'b0}}, val};

  // Two-level OR tree: per-group reduction, then across groups
  generate
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      assign grp_any[g] = |padded[g*GROUP_W +: GROUP_W];
    end
  endgenerate

  assign is_zero = ~|grp_any;

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FUNC_W     = 6,
  parameter int CLASS_W    = 2,
  parameter bit SLT_SIGNED = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CLASS_W-1:0] op_class,
  input  logic [FUNC_W-1:0]  func,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  output logic [DATA_W-1:0]  result,
  output logic               zero
);

  localparam int DEC_W = 4;

  opc_e              opc;
  logic [DATA_W-1:0] y_comb;
  logic              z_comb;
  logic              unused_fn_hi;

  // Upper function bits take no part in the decode
  assign unused_fn_hi = ^func[FUNC_W-1:DEC_W];

  alu_ctl_decode #(
    .CLASS_W (CLASS_W),
    .DEC_W   (DEC_W)
  ) u_dec (
    .op_class (op_class),
    .fn_low   (func[DEC_W-1:0]),
    .opc      (opc)
  );

  alu_core #(
    .DATA_W     (DATA_W),
    .SLT_SIGNED (SLT_SIGNED)
  ) u_core (
    .a   (opnd_a),
    .b   (opnd_b),
    .opc (opc),
    .y   (y_comb)
  );

  zero_detect #(
    .DATA_W  (DATA_W),
    .GROUP_W (8)
  ) u_zd (
    .val     (y_comb),
    .is_zero (z_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b1;
    end else begin
      result <= y_comb;
      zero   <= z_comb;
    end
  end

endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int FUNC_W  = 6,
  parameter int CLASS_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [CLASS_W-1:0] op_class,
  input logic [FUNC_W-1:0]  func,
  input logic [DATA_W-1:0]  opnd_a,
  input logic [DATA_W-1:0]  opnd_b,
  input logic [DATA_W-1:0]  result,
  input logic               zero
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (result == '0) && zero);

  // R9
  zero_match_chk: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));

  // R2
  mem_add_chk: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b00) |=> result == $past(opnd_a + opnd_b));

  // R3
  forced_sub_chk: assert property (@(posedge clk) disable iff (rst)
    op_class[0] |=> result == $past(opnd_a - opnd_b));

  // R5
  and_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b10 && func[3:0] == 4'b0100) |=> result == $past(opnd_a & opnd_b));

  // R7
  slt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b10 && func[3:0] == 4'b1010) |=> result[DATA_W-1:1] == '0);

  // R6
  unlisted_add_chk: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b10 && func[3:0] != 4'b0000 && func[3:0] != 4'b0010 &&
     func[3:0] != 4'b0100 && func[3:0] != 4'b0101 && func[3:0] != 4'b1010)
    |=> result == $past(opnd_a + opnd_b));

endmodule

bind alu_unit alu_unit_chk #(
  .DATA_W  (DATA_W),
  .FUNC_W  (FUNC_W),
  .CLASS_W (CLASS_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_class (op_class),
  .func     (func),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .result   (result),
  .zero     (zero)
);

// File: tb/tb_alu_unit.sv
module tb_alu_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_class = '0;
  logic [5:0]  func = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] result;
  logic        zero;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] exp_res_q[$];
  logic        exp_zero_q[$];
  string       exp_tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  alu_unit dut (
    .clk(clk), .rst(rst), .op_class(op_class), .func(func),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .zero(zero)
  );

  // Reference model written from the requirements
  function automatic logic [31:0] model(input logic [1:0] c, input logic [5:0] f,
                                        input logic [31:0] a, input logic [31:0] b);
    if (c == 2'b00) return a + b;                                 // R2
    if (c[0])       return a - b;                                 // R3
    case (f[3:0])                                                 // R4 R5
      4'b0000: return a + b;
      4'b0010: return a - b;
      4'b0100: return a & b;
      4'b0101: return a | b;
      4'b1010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; // R7
      default: return a + b;                                      // R6
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] r;
    @(negedge clk);
    op_class = c; func = f; opnd_a = a; opnd_b = b;
    r = model(c, f, a, b);
    exp_res_q.push_back(r);
    exp_zero_q.push_back(r == 32'd0);
    exp_tag_q.push_back(tag);
  endtask

  // Monitor: one expected item per edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_res_q.size() > 0) begin
        logic [31:0] er;
        logic        ez;
        string       tg;
        er = exp_res_q.pop_front();
        ez = exp_zero_q.pop_front();
        tg = exp_tag_q.pop_front();
        check(tg, result, er);
        check({tg, " R9 zero"}, {31'd0, zero}, {31'd0, ez});
      end
    end
  end

  task automatic drain();
    while (exp_res_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1: reset dominates non-zero inputs
    op_class = 2'b10; func = 6'b100101; opnd_a = 32'h1234_5678; opnd_b = 32'h0F0F_0F0F;
    repeat (3) @(negedge clk);
    check("R1 result", result, 32'd0);
    check("R1 zero", {31'd0, zero}, 32'd1);
    rst = 1'b0;

    // R2: class 00 adds whatever the function field
    drive(2'b00, 6'b101010, 32'd100, 32'd28, "R2 add ignores func");
    drive(2'b00, 6'b100100, 32'hF0F0_0000, 32'h0000_0F0F, "R2 add");
    // R8 + R9: wrap to zero
    drive(2'b00, 6'b000000, 32'hFFFF_FFFF, 32'd1, "R8 add wrap");
    // R3: forced subtract
    drive(2'b01, 6'b100100, 32'd5, 32'd5, "R3 sub equal");
    drive(2'b11, 6'b100101, 32'd10, 32'd3, "R3 class 11 sub");
    drive(2'b01, 6'b101010, 32'd0, 32'd1, "R8 sub wrap");
    // R4: each listed function
    drive(2'b10, 6'b100000, 32'd7, 32'd9, "R4 add");
    drive(2'b10, 6'b100010, 32'd7, 32'd9, "R4 sub");
    drive(2'b10, 6'b100100, 32'hFF00_FF00, 32'h0FF0_0FF0, "R4 and");
    drive(2'b10, 6'b100101, 32'hFF00_0000, 32'h0000_00FF, "R4 or");
    drive(2'b10, 6'b101010, 32'd3, 32'd4, "R4 slt");
    // R5: upper function bits ignored
    drive(2'b10, 6'b000010, 32'd20, 32'd8, "R5 sub via 000010");
    drive(2'b10, 6'b110100, 32'hAAAA_5555, 32'hFFFF_0000, "R5 and via 110100");
    drive(2'b10, 6'b011010, 32'hFFFF_FFFF, 32'd0, "R5 slt via 011010");
    // R6: unlisted functions add
    drive(2'b10, 6'b100111, 32'd40, 32'd2, "R6 unlisted 100111");
    drive(2'b10, 6'b100110, 32'hFFFF_FFFF, 32'd2, "R6 unlisted 100110");
    drive(2'b10, 6'b001111, 32'd1, 32'd1, "R6 unlisted 001111");
    // R7: signed compare corners
    drive(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'd1, "R7 -1<1");
    drive(2'b10, 6'b101010, 32'd1, 32'hFFFF_FFFF, "R7 1<-1 false");
    drive(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, "R7 min<max");
    drive(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, "R7 max<min false");
    drive(2'b10, 6'b101010, 32'h1234, 32'h1234, "R7 equal");
    drain();

    // R10: outputs hold between edges, update after the edge
    begin
      logic [31:0] prev;
      prev = result;
      drive(2'b00, 6'b0, 32'h0BAD_0000, 32'h0000_F00D, "R10 update");
      #1;
      check("R10 hold before edge", result, prev);
    end
    drain();

    // Mixed patterns
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb;
      logic [5:0]  rf;
      ra = $urandom();
      rb = (i % 5 == 0) ? ra : $urandom();
      rf = 6'($urandom());
      if (i % 3 == 0) rf = {2'($urandom()), 4'b1010};
      drive(2'($urandom()), rf, ra, rb, "R4 R7 mixed");
    end
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // Watchdog
  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule